// File: doc/BRIEF.md
# FIFO-Buffered Serial Peripheral Interface Master

This block is a memory-mapped SPI master. A small register bus gives access to four registers: control, status, data buffer and clock divider. Every register has three write aliases: a plain write, a bit-clear write and a bit-set write. Writes to the data buffer queue transmit words. Reads from the data buffer return received words. A shift engine moves each queued word out on MOSI, MSB first, and captures one word from MISO for each word it sends.

Each direction has a buffer of 16 bytes. The buffer holds 16, 8 or 4 words for 8-, 16- and 32-bit words, or a single word when the deep buffer is disabled. The divider register sets the SCK rate. Control bits select clock polarity, the edge on which data changes, and whether the input is sampled in the middle or at the end of the bit time. The status register reports both fill levels and a sticky receive-overflow flag. An optional automatic slave-select output stays low for as long as there is transmit data queued or a word is in flight.

Top module: `spim_ctrl`

## Requirements
- R1: The address is {register[1:0], alias[1:0]}. Register 0 is control, 1 is status, 2 is the data buffer and 3 is the divider. Alias 0 and 3 write the value as given, alias 1 clears the bits that are set in the data, and alias 2 sets them. Control bit positions: 5 master, 6 polarity, 8 edge, 9 late sample, 11:10 word size, 15 module on, 16 deep buffer, 28 automatic slave select. All 32 control bits read back. The divider reads back as 9 bits.
- R2: Word size code 0 selects 8 bits, 1 selects 16 bits, 2 selects 32 bits, and 3 behaves as 8 bits. Words are shifted MSB first. Only the low word-size bits of a written word are sent, and received words are zero-extended.
- R3: SCK rests at the polarity bit whenever no word is in flight. While shifting, one SCK period lasts 2×(divider+1) clock cycles.
- R4: Each buffer holds 16 bytes: 16, 8 or 4 words for 8-, 16- and 32-bit words, or 1 word when bit 16 is 0. A buffer write to a full transmit buffer is dropped.
- R5: Status bits 20:16 hold the transmit fill level and bits 28:24 the receive fill level, both counted in words.
- R6: Every word that is shifted pushes exactly one received word. With MOSI looped to MISO, the words read back equal the words written, in the same order. Reading an empty receive buffer returns zero.
- R7: Status bit 6 sets when a word completes while the receive buffer is full. That word is dropped. The flag stays set until a status write clears it, for example a clear-alias write with bit 6 set. A clear-alias write with bit 6 at 0 leaves it set.
- R8: With bit 28 set and the module on, ss_n is low while the transmit buffer is not empty or a word is in flight. It stays low between back-to-back words and returns high after the last word ends.
- R9: While bit 15 is 0, both buffers are flushed, writes to the data buffer are dropped, SCK sits at the polarity level and ss_n is high. With the module on but bit 5 at 0, queued words are held and not shifted.
- R10: With bit 8 at 0, SCK leaves its idle level at the start of each bit time, so the first transition comes as soon as a word is loaded. With bit 8 at 1, SCK stays idle for the first half of each bit. Loopback data is correct in every combination of polarity, edge and sample point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; pops the receive buffer when it addresses the data buffer |
| bus_addr | input | 4 | Register index and write alias |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Automatic slave select, active low |

## Verification
The embedded assertions check on every cycle that:
- a push to a full buffer leaves its level unchanged;
- the sticky flag never drops without a status write;
- SCK stays at its idle level and ss_n stays high while the module is off;
- the half-bit phase moves only on a divider tick;
- the bit counter stays below the word size.

Only the bench scenarios can show the things that span a whole exchange. These are MSB-first ordering, loopback data across all three word sizes and clock modes, the measured SCK period, and the capacity that each word size gives. They also cover the slave-select window over back-to-back words, and clearing the flag through the aliases.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam int DATA_W     = 32;
    localparam int FIFO_BYTES = 16;
    localparam int LVL_W      = $clog2(FIFO_BYTES + 1);
    localparam int BAUD_W     = 9;

    typedef enum logic [1:0] {
        RG_CTRL = 2'd0,
        RG_STAT = 2'd1,
        RG_BUF  = 2'd2,
        RG_DIV  = 2'd3
    } reg_e;

    typedef enum logic [1:0] {
        OP_RAW  = 2'd0,
        OP_CLR  = 2'd1,
        OP_SET  = 2'd2,
        OP_RAW2 = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        WS_8   = 2'd0,
        WS_16  = 2'd1,
        WS_32  = 2'd2,
        WS_RSV = 2'd3
    } wsize_e;

    // control bit positions
    localparam int CB_MASTER = 5;
    localparam int CB_CPOL   = 6;
    localparam int CB_CKE    = 8;
    localparam int CB_SMP    = 9;
    localparam int CB_WS_LO  = 10;
    localparam int CB_ON     = 15;
    localparam int CB_ENH    = 16;
    localparam int CB_AUTOSS = 28;

    // status bit positions
    localparam int SB_OVF = 6;
    localparam int SB_TXL = 16;
    localparam int SB_RXL = 24;

    typedef struct packed {
        logic   on;
        logic   master;
        logic   cpol;
        logic   cke;
        logic   smp;
        logic   enh;
        logic   auto_ss;
        wsize_e ws;
    } cfg_t;

    function automatic cfg_t decode_ctrl(input logic [31:0] c);
        cfg_t r;
        r.on      = c[CB_ON];
        r.master  = c[CB_MASTER];
        r.cpol    = c[CB_CPOL];
        r.cke     = c[CB_CKE];
        r.smp     = c[CB_SMP];
        r.enh     = c[CB_ENH];
        r.auto_ss = c[CB_AUTOSS];
        r.ws      = wsize_e'(c[CB_WS_LO+1:CB_WS_LO]);
        return r;
    endfunction

    function automatic logic [5:0] word_bits(input wsize_e ws);
        case (ws)
            WS_16:   return 6'd16;
            WS_32:   return 6'd32;
            default: return 6'd8;
        endcase
    endfunction

    function automatic logic [LVL_W-1:0] word_cap(input wsize_e ws, input logic enh);
        int nbytes;
        nbytes = int'(word_bits(ws)) / 8;
        if (!enh) return LVL_W'(1);
        return LVL_W'((FIFO_BYTES + nbytes - 1) / nbytes);
    endfunction

    function automatic logic [DATA_W-1:0] word_mask(input wsize_e ws);
        logic [DATA_W:0] one_past;
        one_past = (DATA_W+1)'(1) << word_bits(ws);
        return DATA_W'(one_past - 1'b1);
    endfunction

    function automatic logic [31:0] apply_op(input logic [31:0] old,
                                             input logic [31:0] wd,
                                             input op_e op);
        case (op)
            OP_CLR:  return old & ~wd;
            OP_SET:  return old | wd;
            default: return wd;
        endcase
    endfunction

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int ENTRIES = 16,
    parameter int W       = 32,
    parameter int CW      = $clog2(ENTRIES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic [CW-1:0] cap,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    localparam int AW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [W-1:0]  mem [ENTRIES];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign full    = (count >= cap);
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(ENTRIES - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= bump(wp);
            if (do_pop)  rp <= bump(rp);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wp] <= din;
    end

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop && !flush) |=> (count == $past(count))) else $error("full drop");  // R4

endmodule

// File: rtl/spim_baud.sv
module spim_baud #(
    parameter int BW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [BW-1:0] limit,
    output logic          tick
);
    logic [BW-1:0] cnt;

    assign tick = en && (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || !en)  cnt <= '0;
        else if (tick)   cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/spim_shift.sv
module spim_shift
    import spim_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int BW = BAUD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  cfg_t          cfg,
    input  logic [BW-1:0] baud,
    input  logic          tx_valid,
    input  logic [W-1:0]  tx_word,
    output logic          tx_pop,
    output logic          rx_push,
    output logic [W-1:0]  rx_word,
    input  logic          miso,
    output logic          sck,
    output logic          mosi,
    output logic          busy
);
    localparam int CNT_W = $clog2(W);

    logic             busy_q, half_q, tick, last;
    logic [CNT_W-1:0] bit_q;
    logic [W-1:0]     tx_sh, rx_sh, rx_in, load_val;
    logic [5:0]       nbits;
    logic [6:0]       sh_amt;

    spim_baud #(.BW(BW)) u_baud (
        .clk   (clk),
        .rst   (rst),
        .en    (run && busy_q),
        .limit (baud),
        .tick  (tick)
    );

    assign nbits    = word_bits(cfg.ws);
    assign last     = (bit_q == CNT_W'(nbits - 6'd1));
    assign rx_in    = {rx_sh[W-2:0], miso};
    assign sh_amt   = 7'(W) - {1'b0, nbits};
    assign load_val = tx_word << sh_amt;

    assign rx_push  = run && busy_q && tick && half_q && last;
    assign tx_pop   = run && tx_valid && (!busy_q || rx_push);
    assign rx_word  = (cfg.smp ? rx_in : rx_sh) & word_mask(cfg.ws);

    // half A / half B of a bit time; edge bit picks which half drives SCK active
    assign sck  = cfg.cpol ^ (busy_q & ~(half_q ^ cfg.cke));
    assign mosi = busy_q & tx_sh[W-1];
    assign busy = busy_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            busy_q <= 1'b0;
            half_q <= 1'b0;
            bit_q  <= '0;
            tx_sh  <= '0;
            rx_sh  <= '0;
        end else if (tx_pop) begin
            busy_q <= 1'b1;
            half_q <= 1'b0;
            bit_q  <= '0;
            tx_sh  <= load_val;
            rx_sh  <= '0;
        end else if (busy_q && tick) begin
            if (!half_q) begin
                half_q <= 1'b1;
                if (!cfg.smp) rx_sh <= rx_in;
            end else begin
                half_q <= 1'b0;
                tx_sh  <= tx_sh << 1;
                if (cfg.smp) rx_sh <= rx_in;
                if (last) busy_q <= 1'b0;
                else      bit_q  <= bit_q + 1'b1;
            end
        end
    end

    AST_BIT_BOUND: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (7'(bit_q) < 7'(nbits))) else $error("bit bound");  // R2

    AST_HALF_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        (busy_q && $past(busy_q) && run && $past(run) && !$past(tx_pop)
         && (half_q != $past(half_q))) |-> $past(tick)) else $error("half on tick");  // R3

endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
    import spim_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        sck,
    output logic        mosi,
    input  logic        miso,
    output logic        ss_n
);
    logic [31:0]       ctrl_q;
    logic [BAUD_W-1:0] div_q;
    logic              ovf_q;
    cfg_t              cfg;
    reg_e              rsel;
    op_e               op;

    logic [LVL_W-1:0]  cap, tx_lvl, rx_lvl;
    logic [DATA_W-1:0] tx_dout, rx_dout, rx_word;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic              tx_pop, rx_push, busy, run, flush;
    logic [31:0]       stat_word, div_ext;

    assign cfg   = decode_ctrl(ctrl_q);
    assign rsel  = reg_e'(bus_addr[3:2]);
    assign op    = op_e'(bus_addr[1:0]);
    assign cap   = word_cap(cfg.ws, cfg.enh);
    assign run   = cfg.on && cfg.master;
    assign flush = !cfg.on;

    spim_fifo #(.ENTRIES(FIFO_BYTES), .W(DATA_W), .CW(LVL_W)) u_txq (
        .clk   (clk),
        .rst   (rst),
        .flush (flush),
        .cap   (cap),
        .push  (bus_wr && rsel == RG_BUF),
        .din   (bus_wdata),
        .pop   (tx_pop),
        .dout  (tx_dout),
        .count (tx_lvl),
        .full  (tx_full),
        .empty (tx_empty)
    );

    spim_fifo #(.ENTRIES(FIFO_BYTES), .W(DATA_W), .CW(LVL_W)) u_rxq (
        .clk   (clk),
        .rst   (rst),
        .flush (flush),
        .cap   (cap),
        .push  (rx_push),
        .din   (rx_word),
        .pop   (bus_rd && rsel == RG_BUF),
        .dout  (rx_dout),
        .count (rx_lvl),
        .full  (rx_full),
        .empty (rx_empty)
    );

    spim_shift #(.W(DATA_W), .BW(BAUD_W)) u_eng (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .cfg      (cfg),
        .baud     (div_q),
        .tx_valid (!tx_empty),
        .tx_word  (tx_dout),
        .tx_pop   (tx_pop),
        .rx_push  (rx_push),
        .rx_word  (rx_word),
        .miso     (miso),
        .sck      (sck),
        .mosi     (mosi),
        .busy     (busy)
    );

    // register file
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            div_q  <= '0;
        end else if (bus_wr) begin
            if (rsel == RG_CTRL) ctrl_q <= apply_op(ctrl_q, bus_wdata, op);
            if (rsel == RG_DIV)  div_q  <= BAUD_W'(apply_op(div_ext, bus_wdata, op));
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ovf_q <= 1'b0;
        else if (rx_push && rx_full)
            ovf_q <= 1'b1;
        else if (bus_wr && rsel == RG_STAT)
            ovf_q <= apply_op(stat_word, bus_wdata, op)[SB_OVF];
    end

    assign div_ext   = 32'(div_q);
    assign stat_word = (32'(rx_lvl) << SB_RXL) | (32'(tx_lvl) << SB_TXL)
                     | (32'(ovf_q) << SB_OVF);

    always_comb begin
        case (rsel)
            RG_CTRL: bus_rdata = ctrl_q;
            RG_STAT: bus_rdata = stat_word;
            RG_BUF:  bus_rdata = rx_empty ? '0 : rx_dout;
            default: bus_rdata = div_ext;
        endcase
    end

    assign ss_n = !(cfg.on && cfg.auto_ss && (!tx_empty || busy));

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && !(bus_wr && rsel == RG_STAT)) |=> ovf_q) else $error("ovf sticky");  // R7

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        !cfg.on |-> (ss_n && sck == cfg.cpol)) else $error("off quiet");  // R9

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
        (tx_lvl <= LVL_W'(FIFO_BYTES)) && (rx_lvl <= LVL_W'(FIFO_BYTES))) else $error("level");  // R4

    AST_IDLE_SCK: assert property (@(posedge clk) disable iff (rst)
        (tx_empty && !$past(tx_pop) && $past(!busy)) |-> (sck == cfg.cpol)) else $error("idle sck");  // R3

endmodule

// File: tb/sim_spim_ctrl.sv
module sim_spim_ctrl;
    localparam int CLK_PERIOD = 10;

    localparam logic [31:0] K_ON     = 32'h1 << 15;
    localparam logic [31:0] K_MASTER = 32'h1 << 5;
    localparam logic [31:0] K_CPOL   = 32'h1 << 6;
    localparam logic [31:0] K_CKE    = 32'h1 << 8;
    localparam logic [31:0] K_SMP    = 32'h1 << 9;
    localparam logic [31:0] K_ENH    = 32'h1 << 16;
    localparam logic [31:0] K_AUTO   = 32'h1 << 28;
    localparam logic [31:0] K_W16    = 32'h1 << 10;
    localparam logic [31:0] K_W32    = 32'h2 << 10;

    localparam logic [3:0] A_CTRL = 4'h0;
    localparam logic [3:0] A_STAT = 4'h4;
    localparam logic [3:0] A_SCLR = 4'h5;
    localparam logic [3:0] A_BUF  = 4'h8;
    localparam logic [3:0] A_DIV  = 4'hC;
    localparam logic [3:0] A_DCLR = 4'hD;
    localparam logic [3:0] A_DSET = 4'hE;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr = 1'b0, rd = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        sck, mosi, ss_n;
    logic [31:0] mon_sh = '0;
    logic [31:0] cur_mask = 32'hFF;
    logic [31:0] exp_q [$];
    int          n_chk = 0, n_err = 0;
    bit          finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spim_ctrl u0 (
        .clk(clk), .rst(rst), .bus_wr(wr), .bus_rd(rd), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .sck(sck), .mosi(mosi),
        .miso(mosi), .ss_n(ss_n)
    );

    always @(posedge sck) mon_sh <= {mon_sh[30:0], mosi};

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        rd = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver: queue the expected loopback word, then write it
    task automatic send(input logic [31:0] w);
        exp_q.push_back(w & cur_mask);
        bus_write(A_BUF, w);
    endtask

    // monitor: pop the expected word for every word read back
    task automatic drain(input int n, input string tag);
        logic [31:0] d, e;
        for (int i = 0; i < n; i++) begin
            bus_read(A_BUF, d);
            e = (exp_q.size() != 0) ? exp_q.pop_front() : 32'hDEAD_0000;
            check(d == e, tag, d, e);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        realtime t0, t1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state (R1, R9)
        bus_read(A_CTRL, d); check(d == 0, "R1 ctrl reset", d, 0);
        bus_read(A_STAT, d); check(d == 0, "R5 stat reset", d, 0);
        check(ss_n == 1'b1, "R9 ss_n reset", 32'(ss_n), 1);
        check(sck == 1'b0, "R9 sck reset", 32'(sck), 0);

        // R1 alias behaviour on the divider
        bus_write(A_DIV, 32'h0F0);
        bus_write(A_DSET, 32'h003);
        bus_write(A_DCLR, 32'h030);
        bus_read(A_DIV, d); check(d == 32'h0C3, "R1 div aliases", d, 32'h0C3);
        bus_write(A_DIV, 32'h0);

        // R2 R6 R5: 8-bit, idle-low, late-edge change
        cur_mask = 32'hFF;
        bus_write(A_CTRL, K_ON | K_MASTER | K_ENH | K_CKE);
        bus_read(A_CTRL, d); check(d == (K_ON|K_MASTER|K_ENH|K_CKE), "R1 ctrl rb", d, K_ON|K_MASTER|K_ENH|K_CKE);
        send(32'h1E); send(32'hFFA7); send(32'h5C);
        wait_cycles(3*16 + 20);
        bus_read(A_STAT, d);
        check(d[28:24] == 5'd3, "R5 rx level", 32'(d[28:24]), 3);
        check(d[20:16] == 5'd0, "R5 tx level", 32'(d[20:16]), 0);
        check(mon_sh[23:0] == 24'h1EA75C, "R2 msb first", mon_sh, 32'h1EA75C);
        drain(3, "R6 loopback 8");
        bus_read(A_BUF, d); check(d == 0, "R6 empty read", d, 0);

        // R10 R2: 16-bit, idle-high, early change, late sample
        cur_mask = 32'hFFFF;
        bus_write(A_DIV, 32'h1);
        bus_write(A_CTRL, K_ON | K_MASTER | K_ENH | K_CPOL | K_SMP | K_W16);
        send(32'hBEEF); send(32'hFFFF1234);
        wait_cycles(2*16*4 + 20);
        check(sck == 1'b1, "R3 idle high", 32'(sck), 1);
        drain(2, "R10 loopback 16");

        // R2: 32-bit
        cur_mask = 32'hFFFF_FFFF;
        bus_write(A_DIV, 32'h0);
        bus_write(A_CTRL, K_ON | K_MASTER | K_ENH | K_CKE | K_SMP | K_W32);
        send(32'hDEADBEEF); send(32'h01234567);
        wait_cycles(2*64 + 20);
        drain(2, "R2 loopback 32");

        // R10 edge selection
        cur_mask = 32'hFF;
        bus_write(A_DIV, 32'h3);
        bus_write(A_CTRL, K_ON | K_MASTER | K_ENH);
        send(32'h81);
        @(negedge clk);
        check(sck == 1'b1, "R10 early edge", 32'(sck), 1);
        wait_cycles(8*8 + 10);
        drain(1, "R10 loopback cke0");
        bus_write(A_CTRL, K_ON | K_MASTER | K_ENH | K_CKE);
        send(32'h42);
        @(negedge clk);
        check(sck == 1'b0, "R10 late edge", 32'(sck), 0);
        wait_cycles(8*8 + 10);
        drain(1, "R10 loopback cke1");

        // R3 SCK period with divider 2
        bus_write(A_DIV, 32'h2);
        send(32'h55);
        @(posedge sck); t0 = $realtime;
        @(posedge sck); t1 = $realtime;
        check(int'((t1 - t0) / CLK_PERIOD) == 6, "R3 period",
              32'(int'((t1 - t0) / CLK_PERIOD)), 6);
        wait_cycles(6*8 + 10);
        drain(1, "R6 loopback div2");

        // R8 automatic slave select
        bus_write(A_DIV, 32'h0);
        bus_write(A_CTRL, K_ON | K_MASTER | K_ENH | K_CKE | K_AUTO);
        check(ss_n == 1'b1, "R8 ss idle", 32'(ss_n), 1);
        send(32'hC3);
        check(ss_n == 1'b0, "R8 ss asserted", 32'(ss_n), 0);
        send(32'h3C);
        wait_cycles(14);
        check(ss_n == 1'b0, "R8 ss held between words", 32'(ss_n), 0);
        wait_cycles(2*16 + 10);
        check(ss_n == 1'b1, "R8 ss released", 32'(ss_n), 1);
        drain(2, "R8 loopback");

        // R4 capacity per word size, R9 flush
        bus_write(A_CTRL, K_ON | K_ENH | K_W32);
        for (int i = 0; i < 6; i++) bus_write(A_BUF, 32'(i));
        bus_read(A_STAT, d); check(d[20:16] == 5'd4, "R4 cap 32", 32'(d[20:16]), 4);
        bus_write(A_CTRL, 32'h0);
        bus_read(A_STAT, d); check(d[20:16] == 5'd0, "R9 flush", 32'(d[20:16]), 0);
        bus_write(A_CTRL, K_ON | K_ENH);
        for (int i = 0; i < 17; i++) bus_write(A_BUF, 32'(i));
        bus_read(A_STAT, d); check(d[20:16] == 5'd16, "R4 cap 8", 32'(d[20:16]), 16);
        bus_write(A_CTRL, 32'h0);
        bus_write(A_CTRL, K_ON | K_ENH | K_W16);
        for (int i = 0; i < 9; i++) bus_write(A_BUF, 32'(i));
        bus_read(A_STAT, d); check(d[20:16] == 5'd8, "R4 cap 16", 32'(d[20:16]), 8);
        bus_write(A_CTRL, 32'h0);
        bus_write(A_CTRL, K_ON);
        for (int i = 0; i < 3; i++) bus_write(A_BUF, 32'(i));
        bus_read(A_STAT, d); check(d[20:16] == 5'd1, "R4 shallow", 32'(d[20:16]), 1);
        bus_write(A_CTRL, 32'h0);
        bus_write(A_BUF, 32'h77);
        bus_write(A_CTRL, K_ON | K_ENH);
        bus_read(A_STAT, d); check(d[20:16] == 5'd0, "R9 write while off", 32'(d[20:16]), 0);

        // R7 overflow
        bus_write(A_CTRL, K_ON | K_MASTER | K_ENH | K_CKE);
        for (int i = 0; i < 16; i++) send(32'(8'h20 + i));
        bus_write(A_BUF, 32'hAA);
        bus_write(A_BUF, 32'hBB);
        wait_cycles(18*16 + 40);
        bus_read(A_STAT, d);
        check(d[28:24] == 5'd16, "R7 rx full", 32'(d[28:24]), 16);
        check(d[6] == 1'b1, "R7 ovf set", 32'(d[6]), 1);
        bus_write(A_SCLR, 32'h0);
        bus_read(A_STAT, d); check(d[6] == 1'b1, "R7 ovf kept", 32'(d[6]), 1);
        bus_write(A_SCLR, 32'h40);
        bus_read(A_STAT, d); check(d[6] == 1'b0, "R7 ovf cleared", 32'(d[6]), 0);
        drain(16, "R7 kept words");

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule